// File: doc/BRIEF.md
# Back-End Stall Cause Counters

This block charges every cycle in which the back end holds up instruction dispatch to one cause. A cycle counts as a back-end stall only when the reorder buffer reports full and dispatch is stalled in the same cycle. In such a cycle, the event flags of the oldest instruction, the one at the reorder-buffer head, pick the single counter that is incremented. The flags cover four events: an outstanding data-TLB miss, an outstanding second-level data-cache miss, an outstanding first-level data-cache miss, and a long-latency functional unit such as a divider. A stall cycle whose head instruction has no flag set is charged to an "other" counter.

A free-running total-cycle counter sits next to the cause counters. Performance software can therefore compare each cause against elapsed time. All counters are `CNT_W` bits wide (32 by default) and saturate at their maximum value. A synchronous clear input sets every counter to zero. This block does not generate the miss flags, and it does not model the cache hierarchy.

Top module: `stall_cause_counters`

## Requirements
- R1: After reset, all six counters read zero.
- R2: The total counter increases by one every clock cycle in which clear is low, whether or not a stall is present.
- R3: In a cycle where robFull and dispStall are not both 1, no cause counter changes, whatever the head flags are.
- R4: In a stall cycle (robFull=1 and dispStall=1, clear=0), exactly one cause counter increases by one and the other four hold their values.
- R5: A stall cycle with headDtlb=1 is charged to dtlbCnt, regardless of the other flags.
- R6: A stall cycle with headDtlb=0 and headL2=1 is charged to l2Cnt, regardless of headL1 and headLongFu.
- R7: A stall cycle with headDtlb=0, headL2=0 and headL1=1 is charged to l1Cnt, regardless of headLongFu.
- R8: A stall cycle where headLongFu is the only flag set is charged to fuCnt.
- R9: A stall cycle with no head flag set is charged to otherCnt.
- R10: Clear=1 sets all six counters to zero on the next clock edge. Clear takes priority over any increment in that cycle.
- R11: A counter at its maximum value (2^CNT_W - 1) stays there when it would otherwise increase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all counters |
| robFull | input | 1 | Reorder buffer is full |
| dispStall | input | 1 | Dispatch is stalled this cycle |
| headDtlb | input | 1 | Head instruction has an outstanding data-TLB miss |
| headL2 | input | 1 | Head instruction has an outstanding second-level data-cache miss |
| headL1 | input | 1 | Head instruction has an outstanding first-level data-cache miss |
| headLongFu | input | 1 | Head instruction waits on a long-latency functional unit |
| totalCnt | output | CNT_W | Total cycle count |
| dtlbCnt | output | CNT_W | Stall cycles charged to data-TLB miss |
| l2Cnt | output | CNT_W | Stall cycles charged to second-level miss |
| l1Cnt | output | CNT_W | Stall cycles charged to first-level miss |
| fuCnt | output | CNT_W | Stall cycles charged to long-latency unit |
| otherCnt | output | CNT_W | Stall cycles with no flagged head instruction |

## Verification
Random cycles mix full and non-full reorder-buffer states, stalled and flowing dispatch, and independent head flags. Within these, full-but-flowing and stalled-but-not-full cycles test that both gating conditions are required. Directed cycles apply every flag overlap that matters for priority: all four flags at once, L2 together with L1 and the long unit, L1 together with the long unit, and a lone long-unit flag. Each of these tells apart a correct encoder from one that has two adjacent priorities swapped. Further cases raise clear together with a stall, and hold a narrow-width instance in a long stall to drive it into saturation.

// File: rtl/stall_cause_pkg.sv
`timescale 1ns/1ps
package stall_cause_pkg;
  localparam int NCAUSE = 5;
  localparam int NCNT   = NCAUSE + 1;
  // Counter slots; the cause order here is also the priority order.
  localparam int IDX_DTLB  = 0;
  localparam int IDX_L2    = 1;
  localparam int IDX_L1    = 2;
  localparam int IDX_FU    = 3;
  localparam int IDX_OTHER = 4;
  localparam int IDX_TOTAL = 5;

  typedef struct packed {
    logic              clr;
    logic              incTotal;
    logic [NCAUSE-1:0] incCause;
  } ctrl_strb_t;
endpackage

// File: rtl/stall_cause_ctrl.sv
`timescale 1ns/1ps
module stall_cause_ctrl
  import stall_cause_pkg::*;
(
  input  logic       clear,
  input  logic       robFull,
  input  logic       dispStall,
  input  logic       headDtlb,
  input  logic       headL2,
  input  logic       headL1,
  input  logic       headLongFu,
  output ctrl_strb_t strb
);
  logic backStall;
  logic [NCAUSE-2:0] flagVec;

  assign backStall = robFull & dispStall;
  assign flagVec   = {headLongFu, headL1, headL2, headDtlb};

  // Fixed priority: lowest index wins, no flag means "other".
  always_comb begin
    strb          = '0;
    strb.clr      = clear;
    strb.incTotal = ~clear;
    if (!clear && backStall) begin
      if (flagVec == '0) begin
        strb.incCause[IDX_OTHER] = 1'b1;
      end else begin
        for (int i = NCAUSE - 2; i >= 0; i--) begin
          if (flagVec[i]) begin
            strb.incCause    = '0;
            strb.incCause[i] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stall_cause_dp.sv
`timescale 1ns/1ps
module stall_cause_dp
  import stall_cause_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strb_t                 strb,
  output logic [NCNT-1:0][CNT_W-1:0] cntVec
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NCNT-1:0] incVec;
  assign incVec = {strb.incTotal, strb.incCause};

  for (genvar g = 0; g < NCNT; g++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cntQ <= '0;
      else if (strb.clr)                  cntQ <= '0;
      else if (incVec[g] && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
    end
    assign cntVec[g] = cntQ;
  end

  // R4
  one_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.incCause));
endmodule

// File: rtl/stall_cause_counters.sv
`timescale 1ns/1ps
module stall_cause_counters
  import stall_cause_pkg::*;
#(
  parameter int CNT_W = 32
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             robFull,
  input  logic             dispStall,
  input  logic             headDtlb,
  input  logic             headL2,
  input  logic             headL1,
  input  logic             headLongFu,
  output logic [CNT_W-1:0] totalCnt,
  output logic [CNT_W-1:0] dtlbCnt,
  output logic [CNT_W-1:0] l2Cnt,
  output logic [CNT_W-1:0] l1Cnt,
  output logic [CNT_W-1:0] fuCnt,
  output logic [CNT_W-1:0] otherCnt
);
  localparam logic [CNT_W-1:0] TOP_MAX = {CNT_W{1'b1}};

  ctrl_strb_t strb;
  logic [NCNT-1:0][CNT_W-1:0] cntVec;

  stall_cause_ctrl uCtrl (
    .clear(clear), .robFull(robFull), .dispStall(dispStall),
    .headDtlb(headDtlb), .headL2(headL2), .headL1(headL1),
    .headLongFu(headLongFu), .strb(strb)
  );

  stall_cause_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVec(cntVec)
  );

  assign dtlbCnt  = cntVec[IDX_DTLB];
  assign l2Cnt    = cntVec[IDX_L2];
  assign l1Cnt    = cntVec[IDX_L1];
  assign fuCnt    = cntVec[IDX_FU];
  assign otherCnt = cntVec[IDX_OTHER];
  assign totalCnt = cntVec[IDX_TOTAL];

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(robFull && dispStall) && !clear) |=>
      ($stable(dtlbCnt) && $stable(l2Cnt) && $stable(l1Cnt) &&
       $stable(fuCnt) && $stable(otherCnt)));

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (totalCnt == '0 && dtlbCnt == '0 && l2Cnt == '0 &&
               l1Cnt == '0 && fuCnt == '0 && otherCnt == '0));

  // R2
  total_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && totalCnt != TOP_MAX) |=> totalCnt == $past(totalCnt) + 1'b1);

  // R5
  dtlb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (robFull && dispStall && headDtlb && !clear && dtlbCnt != TOP_MAX)
      |=> dtlbCnt == $past(dtlbCnt) + 1'b1);

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && totalCnt == TOP_MAX) |=> totalCnt == TOP_MAX);
endmodule

// File: tb/tb_stall_cause_counters.sv
`timescale 1ns/1ps
module tb_stall_cause_counters;
  localparam int W  = 32;
  localparam int WN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 0, robFull = 0, dispStall = 0;
  logic headDtlb = 0, headL2 = 0, headL1 = 0, headLongFu = 0;
  logic [W-1:0]  tot, dt, l2, l1, fu, ot;
  logic [WN-1:0] totN, dtN, l2N, l1N, fuN, otN;

  int nChk = 0, nFail = 0;
  longint unsigned expW [6];
  longint unsigned expN [6];

  always #10 clk = ~clk;

  stall_cause_counters #(.CNT_W(W)) dut (
    .clk(clk), .rstN(rstN), .clear(clear), .robFull(robFull),
    .dispStall(dispStall), .headDtlb(headDtlb), .headL2(headL2),
    .headL1(headL1), .headLongFu(headLongFu), .totalCnt(tot),
    .dtlbCnt(dt), .l2Cnt(l2), .l1Cnt(l1), .fuCnt(fu), .otherCnt(ot));

  stall_cause_counters #(.CNT_W(WN)) dutNarrow (
    .clk(clk), .rstN(rstN), .clear(clear), .robFull(robFull),
    .dispStall(dispStall), .headDtlb(headDtlb), .headL2(headL2),
    .headL1(headL1), .headLongFu(headLongFu), .totalCnt(totN),
    .dtlbCnt(dtN), .l2Cnt(l2N), .l1Cnt(l1N), .fuCnt(fuN), .otherCnt(otN));

  // Index of the cause a stall cycle should be charged to.
  function automatic int causeOf(logic d, logic b, logic a, logic f);
    if (d) return 0;
    if (b) return 1;
    if (a) return 2;
    if (f) return 3;
    return 4;
  endfunction

  function automatic longint unsigned satInc(longint unsigned v, int w);
    longint unsigned mx = (64'd1 << w) - 1;
    return (v >= mx) ? mx : v + 1;
  endfunction

  function automatic string reqOf(int idx, logic c, logic st, int win, logic narrowSat);
    if (c) return "R10";
    if (narrowSat) return "R11";
    if (idx == 5) return "R2";
    if (!st) return "R3";
    if (idx != win) return "R4";
    case (win)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic cmp(string req, string nm, longint unsigned act, longint unsigned exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  task automatic compareAll(logic c, logic st, int win);
    longint unsigned aW [6];
    longint unsigned aN [6];
    aW = '{dt, l2, l1, fu, ot, tot};
    aN = '{dtN, l2N, l1N, fuN, otN, totN};
    for (int i = 0; i < 6; i++) begin
      cmp(reqOf(i, c, st, win, 1'b0), "wide", aW[i], expW[i]);
      cmp(reqOf(i, c, st, win, expN[i] == (1 << WN) - 1), "narrow", aN[i], expN[i]);
    end
  endtask

  // Drive one cycle at a negedge, update the models at the posedge, compare at the next negedge.
  task automatic step(logic rf, logic ds, logic d, logic b, logic a, logic f, logic c);
    logic st;
    int win;
    robFull = rf; dispStall = ds; headDtlb = d; headL2 = b; headL1 = a;
    headLongFu = f; clear = c;
    st  = rf & ds;
    win = causeOf(d, b, a, f);
    @(posedge clk);
    if (c) begin
      for (int i = 0; i < 6; i++) begin expW[i] = 0; expN[i] = 0; end
    end else begin
      expW[5] = satInc(expW[5], W);
      expN[5] = satInc(expN[5], WN);
      if (st) begin
        expW[win] = satInc(expW[win], W);
        expN[win] = satInc(expN[win], WN);
      end
    end
    @(negedge clk);
    compareAll(c, st, win);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    nFail++;
    nChk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20061;
    void'($urandom(seed));
    for (int i = 0; i < 6; i++) begin expW[i] = 0; expN[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    compareAll(1'b0, 1'b0, 4);

    // R3: flags present but no full+stall pair
    step(1, 0, 1, 1, 1, 1, 0);
    step(0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    // R5..R9 priority corners
    step(1, 1, 1, 1, 1, 1, 0);
    step(1, 1, 0, 1, 1, 1, 0);
    step(1, 1, 0, 0, 1, 1, 0);
    step(1, 1, 0, 0, 0, 1, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 1, 0);
    // R10: clear wins over a stall
    step(1, 1, 1, 1, 0, 0, 1);
    step(1, 1, 0, 1, 0, 0, 0);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) < 6, ($urandom % 10) < 6,
           ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 4) == 0, ($urandom % 4) == 0,
           ($urandom % 100) == 0);
    end

    // R11: long DTLB stall drives the narrow counters into saturation
    step(0, 0, 0, 0, 0, 0, 1);
    for (int n = 0; n < 24; n++) step(1, 1, 1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule